// File: doc/BRIEF.md
# Latched Error Status Register

This block is the error status register of an interrupt controller, built from two storage stages. A live register, which software cannot see, gathers one-cycle error event pulses from the rest of the controller. Each bit is set by its event and stays set until a clearing action removes it. A snapshot latch is the value software reads. Software reaches the block over a simple register bus with a select, a write strobe, a read strobe and 32-bit data. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure: every bus access completes in the cycle it is presented.

Under the modern semantics, any write moves the live bits into the snapshot and clears the live bits. A read returns the snapshot and has no side effect. Clearing the visible value therefore takes two writes in a row. If an error arrives between those two writes, the snapshot is not zero after the second write, so software repeats the write-then-read sequence until it reads zero. Under the legacy semantics, a read returns the live bits and clears them, and a write does nothing. A build parameter can reproduce a known defect in which a legacy write also clears the live bits.

The error interrupt depends only on the live bits. It is a one-cycle pulse each time the live register goes from empty to non-empty, unless a mask input suppresses it.

Top module: `errlatch_csr`

## Requirements
- R1: Modern mode (`legacy_mode`=0): a read with `reg_sel`=1 and `reg_rd`=1 loads `reg_rdata` with the snapshot, as it stood before that edge, in the cycle after the strobe. `reg_rdata` holds that value until the next read. A read changes neither the snapshot nor the live bits.
- R2: Modern mode: a write (`reg_sel`=1, `reg_wr`=1) copies the live bits into the snapshot and clears the live bits at the same clock edge. The value on `reg_wdata` has no effect.
- R3: Modern mode: two writes in a row leave the snapshot at zero when no event arrives between them. If an event arrives between them, the snapshot is non-zero after the second write.
- R4: `irq_pulse` is high for exactly one cycle, in the cycle after the live register goes from all-zero to non-zero. The snapshot never affects it.
- R5: When `irq_mask` is 1 at the edge where the live register becomes non-zero, no pulse is produced for that transition.
- R6: Legacy mode (`legacy_mode`=1), with the defect parameter `LEGACY_WR_BUG`=0: a read returns the live bits as they stood before the edge and clears them. A write has no effect on either stage.
- R7: With `LEGACY_WR_BUG`=1, a legacy-mode write clears the live bits. A read that follows such a write with no event in between returns zero.
- R8: Error bits accumulate. Event bit i sets field bit i, and a set bit stays set until a clearing write (modern mode) or a clearing read (legacy mode).
- R9: An event that arrives at the same edge as a clearing access is kept in the live register after the clear.
- R10: The error field is `reg_rdata[7:0]`, with bit i reporting event input i. Bits 31:8 always read as zero.
- R11: Reset clears the live register, the snapshot, `reg_rdata` and `irq_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data (ignored) |
| reg_rdata | output | 32 | Read data, registered |
| err_evt | input | 8 | Set-only error event pulses, one per error class |
| legacy_mode | input | 1 | 0 = modern snapshot semantics, 1 = legacy read-to-clear |
| irq_mask | input | 1 | Suppresses the interrupt pulse |
| irq_pulse | output | 1 | Error interrupt pulse |

## Verification
The assertions check, on every cycle, that the interrupt pulse lasts one cycle, comes only from an empty-to-non-empty live transition, and stays quiet under the mask. They also check that live bits never drop without a bus access, that a coincident event always survives, that a modern read leaves the snapshot unchanged, that a modern write captures the prior live value, and that the upper read bits stay zero. Only the bench scenarios can show the software-level sequences: the two-write clear and its failure when an event falls between the writes, the legacy read-to-clear, and the difference the defect parameter makes when two instances receive identical traffic.

// File: rtl/errlatch_pkg.sv
package errlatch_pkg;
  typedef enum logic {
    MODE_MODERN = 1'b0,
    MODE_LEGACY = 1'b1
  } esr_mode_e;

  typedef struct packed {
    logic snap;   // copy live into snapshot
    logic clr;    // clear live bits (events still merge in)
    logic rd;     // capture read data
  } esr_ctl_t;
endpackage

// File: rtl/errlatch_live.sv
module errlatch_live #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ERR_W-1:0] evt,
  output logic [ERR_W-1:0] live_q,
  output logic [ERR_W-1:0] live_d
);
  for (genvar b = 0; b < ERR_W; b++) begin : g_bit
    // sticky bit: a clear drops history, a same-edge event survives it
    assign live_d[b] = (live_q[b] & ~clr) | evt[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q[b] <= 1'b0;
      else        live_q[b] <= live_d[b];
    end
  end
endmodule

// File: rtl/errlatch_snap.sv
module errlatch_snap #(
  parameter int ERR_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap,
  input  logic              rd,
  input  logic              legacy,
  input  logic [ERR_W-1:0]  live,
  output logic [ERR_W-1:0]  latch_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - ERR_W;

  logic [ERR_W-1:0]  rd_src;
  logic [DATA_W-1:0] rdata_d;

  assign rd_src  = legacy ? live : latch_q;
  assign rdata_d = {{PAD_W{1'b0}}, rd_src};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch_q <= '0;
    else if (snap)  latch_q <= live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata <= '0;
    else if (rd)  rdata <= rdata_d;
  end
endmodule

// File: rtl/errlatch_irq.sv
module errlatch_irq #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] live_q,
  input  logic [ERR_W-1:0] live_d,
  input  logic             mask,
  output logic             irq
);
  logic rising;

  assign rising = ~(|live_q) & (|live_d) & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= rising;
  end
endmodule

// File: rtl/errlatch_csr.sv
module errlatch_csr
  import errlatch_pkg::*;
#(
  parameter int ERR_W         = 8,
  parameter int DATA_W        = 32,
  parameter bit LEGACY_WR_BUG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ERR_W-1:0]  err_evt,
  input  logic              legacy_mode,
  input  logic              irq_mask,
  output logic              irq_pulse
);
  esr_mode_e        mode;
  esr_ctl_t         ctl;
  logic             wr_hit, rd_hit, wdata_unused;
  logic [ERR_W-1:0] live_q, live_d, latch_q;

  assign mode         = esr_mode_e'(legacy_mode);
  assign wr_hit       = reg_sel & reg_wr;
  assign rd_hit       = reg_sel & reg_rd;
  assign wdata_unused = ^reg_wdata;

  always_comb begin
    ctl.rd = rd_hit;
    if (mode == MODE_MODERN) begin
      ctl.snap = wr_hit;
      ctl.clr  = wr_hit;
    end else begin
      ctl.snap = 1'b0;
      ctl.clr  = rd_hit | (LEGACY_WR_BUG & wr_hit);
    end
  end

  errlatch_live #(.ERR_W(ERR_W)) u_live (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ctl.clr),
    .evt    (err_evt),
    .live_q (live_q),
    .live_d (live_d)
  );

  errlatch_snap #(.ERR_W(ERR_W), .DATA_W(DATA_W)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .snap    (ctl.snap),
    .rd      (ctl.rd),
    .legacy  (mode == MODE_LEGACY),
    .live    (live_q),
    .latch_q (latch_q),
    .rdata   (reg_rdata)
  );

  errlatch_irq #(.ERR_W(ERR_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .live_q (live_q),
    .live_d (live_d),
    .mask   (irq_mask),
    .irq    (irq_pulse)
  );
endmodule

// File: rtl/errlatch_csr_chk.sv
module errlatch_csr_chk #(
  parameter int ERR_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [ERR_W-1:0]  err_evt,
  input logic              legacy_mode,
  input logic              irq_mask,
  input logic              irq_pulse,
  input logic [ERR_W-1:0]  live,
  input logic [ERR_W-1:0]  latch
);
  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (live != '0) && ($past(live) == '0));

  // R5
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |=> !irq_pulse);

  // R8
  live_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_sel && (reg_wr || reg_rd)) |=> ((live & $past(live)) == $past(live)));

  // R9
  evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((live & $past(err_evt)) == $past(err_evt)));

  // R1
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_rd && !reg_wr && !legacy_mode) |=> $stable(latch));

  // R2
  write_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && !legacy_mode) |=> latch == $past(live));

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:ERR_W] == '0);
endmodule

bind errlatch_csr errlatch_csr_chk #(.ERR_W(ERR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_sel     (reg_sel),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_rdata   (reg_rdata),
  .err_evt     (err_evt),
  .legacy_mode (legacy_mode),
  .irq_mask    (irq_mask),
  .irq_pulse   (irq_pulse),
  .live        (live_q),
  .latch       (latch_q)
);

// File: tb/test_errlatch_csr.sv
`timescale 1ns/1ps
module test_errlatch_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_wr, reg_rd, legacy_mode, irq_mask;
  logic [31:0] reg_wdata;
  logic [7:0]  err_evt;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state, index 0: defect off, index 1: defect on
  logic [7:0]  m_live [2];
  logic [7:0]  m_latch[2];
  logic [31:0] m_rdata[2];
  logic        m_irq  [2];

  always #5 clk = ~clk;

  errlatch_csr i_errlatch_csr (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(rdata0),
    .err_evt(err_evt), .legacy_mode(legacy_mode), .irq_mask(irq_mask),
    .irq_pulse(irq0));

  errlatch_csr #(.LEGACY_WR_BUG(1'b1)) i_errlatch_csr_bug (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(rdata1),
    .err_evt(err_evt), .legacy_mode(legacy_mode), .irq_mask(irq_mask),
    .irq_pulse(irq1));

  function automatic logic [7:0] next_live(logic [7:0] live, logic clr, logic [7:0] evt);
    return (clr ? 8'h00 : live) | evt;
  endfunction

  task automatic check(string tag, int idx, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s inst%0d: got %h expected %h", tag, idx, act, exp);
    end
  endtask

  task automatic model_edge();
    for (int i = 0; i < 2; i++) begin
      logic wr_hit, rd_hit, clr;
      logic [7:0] nl;
      wr_hit = reg_sel & reg_wr;
      rd_hit = reg_sel & reg_rd;
      clr = legacy_mode ? (rd_hit | ((i == 1) & wr_hit)) : wr_hit;
      if (rd_hit) m_rdata[i] = {24'h0, legacy_mode ? m_live[i] : m_latch[i]};
      if (!legacy_mode && wr_hit) m_latch[i] = m_live[i];
      nl = next_live(m_live[i], clr, err_evt);
      m_irq[i] = (m_live[i] == 8'h00) && (nl != 8'h00) && !irq_mask;
      m_live[i] = nl;
    end
  endtask

  task automatic compare(string tag);
    check({tag, " rdata"}, 0, rdata0, m_rdata[0]);
    check({tag, " rdata"}, 1, rdata1, m_rdata[1]);
    check({tag, " irq"},   0, {31'h0, irq0}, {31'h0, m_irq[0]});
    check({tag, " irq"},   1, {31'h0, irq1}, {31'h0, m_irq[1]});
  endtask

  // drive one cycle of bus and events, then compare after the edge
  task automatic cyc(string tag, logic sel, logic wr, logic rd,
                     logic [7:0] evt, logic leg, logic msk);
    reg_sel = sel; reg_wr = wr; reg_rd = rd; err_evt = evt;
    legacy_mode = leg; irq_mask = msk;
    reg_wdata = $urandom();
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
  endtask

  task automatic wr_op(string tag, logic [7:0] evt, logic leg);
    cyc(tag, 1'b1, 1'b1, 1'b0, evt, leg, 1'b0);
  endtask
  task automatic rd_op(string tag, logic [7:0] evt, logic leg);
    cyc(tag, 1'b1, 1'b0, 1'b1, evt, leg, 1'b0);
  endtask
  task automatic idle(string tag, logic [7:0] evt, logic leg, logic msk);
    cyc(tag, 1'b0, 1'b0, 1'b0, evt, leg, msk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0001));
    rst_n = 1'b0; reg_sel = 0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    err_evt = '0; legacy_mode = 0; irq_mask = 0;
    for (int i = 0; i < 2; i++) begin
      m_live[i] = '0; m_latch[i] = '0; m_rdata[i] = '0; m_irq[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    compare("R11 reset");
    rst_n = 1'b1;

    // R4 first event raises a pulse, then it drops
    idle("R4 rise", 8'h05, 0, 0);
    check("R4 pulse", 0, {31'h0, irq0}, 32'h1);
    idle("R4 one-cycle", 8'h00, 0, 0);
    check("R4 pulse end", 0, {31'h0, irq0}, 32'h0);
    // R1 read shows empty snapshot, not live bits
    rd_op("R1 snapshot only", 8'h00, 0);
    check("R1 read", 0, rdata0, 32'h0);
    // R2 write snapshots, data ignored
    wr_op("R2 write", 8'h00, 0);
    rd_op("R2 read", 8'h00, 0);
    check("R2 read", 0, rdata0, 32'h5);
    rd_op("R1 repeat read", 8'h00, 0);
    check("R1 no side effect", 0, rdata0, 32'h5);
    // R3 second write zeroes the snapshot
    wr_op("R3 second write", 8'h00, 0);
    rd_op("R3 read", 8'h00, 0);
    check("R3 cleared", 0, rdata0, 32'h0);
    // R3 event between writes
    idle("R3 evt", 8'h10, 0, 0);
    wr_op("R3 w1", 8'h00, 0);
    idle("R3 evt2", 8'h20, 0, 0);
    wr_op("R3 w2", 8'h00, 0);
    rd_op("R3 read", 8'h00, 0);
    check("R3 not cleared", 0, rdata0, 32'h20);
    // R4 snapshot nonzero with live empty: no pulse
    idle("R4 latch only", 8'h00, 0, 0);
    check("R4 latch no irq", 0, {31'h0, irq0}, 32'h0);
    // R9 event at the same edge as a clearing write
    wr_op("R9 w", 8'h40, 0);
    wr_op("R9 w", 8'h00, 0);
    rd_op("R9 read", 8'h00, 0);
    check("R9 kept", 0, rdata0, 32'h40);
    // R5 mask
    idle("R5 masked", 8'h01, 0, 1);
    check("R5 masked", 0, {31'h0, irq0}, 32'h0);
    // R8 accumulation
    idle("R8 acc", 8'h02, 0, 0);
    idle("R8 acc", 8'h80, 0, 0);
    wr_op("R8 w", 8'h00, 0);
    rd_op("R8 read", 8'h00, 0);
    check("R8 accumulate", 0, rdata0, 32'h83);
    wr_op("R8 clr", 8'h00, 0);
    // R6 legacy read-to-clear
    idle("R6 evt", 8'h0C, 1, 0);
    rd_op("R6 read", 8'h00, 1);
    check("R6 live read", 0, rdata0, 32'h0C);
    rd_op("R6 read2", 8'h00, 1);
    check("R6 cleared", 0, rdata0, 32'h0);
    // R6 / R7 legacy write
    idle("R7 evt", 8'h03, 1, 0);
    wr_op("R7 write", 8'h00, 1);
    rd_op("R7 read", 8'h00, 1);
    check("R6 write ignored", 0, rdata0, 32'h03);
    check("R7 write clears", 1, rdata1, 32'h0);
    // R9 legacy read with coincident event
    rd_op("R9 leg", 8'h11, 1);
    rd_op("R9 leg read", 8'h00, 1);
    check("R9 legacy kept", 0, rdata0, 32'h11);

    // R10 / all: constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ev;
      ev = ($urandom_range(0, 3) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      cyc("R10 random", $urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0,
          $urandom_range(0, 2) == 0, ev, $urandom_range(0, 7) == 0,
          $urandom_range(0, 5) == 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule